// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block joins two eight-line interrupt units, a primary and a secondary, into one sixteen-line interrupt controller for a CPU. Request inputs 0 to 7 feed the primary unit and inputs 8 to 15 feed the secondary. Whenever the secondary unit has a request that beats its own in-service level, that request is forwarded onto primary line 2, the cascade line. The primary unit then raises the CPU interrupt output.

When the CPU pulses the acknowledge strobe, the unit resolves the vector in two stages. First the primary winner is taken. If that winner is the cascade line, the secondary winner is taken as well. Requests that disappear before the acknowledge produce a spurious vector, which is line 7 of the unit involved. Each unit holds a trigger-mode byte that selects edge or level sensing per line. Some bits of each byte are fixed at zero by a mask. A specific end-of-service strobe releases one in-service line.

Each unit uses fixed nested priority: a lower line number wins, and a pending line is only offered when its number is below every in-service line of that unit.

Top module: `cascade_intack`

## Requirements
- R1: Among pending primary lines the lowest number wins; acknowledging primary line n (n not 2) returns vector PRI_VBASE+n (default 0x08+n) one cycle after the strobe and marks that line in service.
- R2: A request on input 8+k forwarded through the cascade line raises int_o two cycles after the input rises; its acknowledge returns SEC_VBASE+k (default 0x70+k).
- R3: A pending line whose number is not below the lowest in-service line of its unit does not assert int_o; an end-of-service strobe (eoi_line_i = unit*8 + line) clears that in-service bit one cycle later.
- R4: If the primary wins on the cascade line but the secondary has nothing pending at the acknowledge, the vector is SEC_VBASE+7; primary line 2 still enters service.
- R5: If the primary has no qualifying request at the acknowledge, the vector is PRI_VBASE+7 and no in-service or pending state changes.
- R6: A write to a trigger-mode byte (trig_sel_i 0 = primary, 1 = secondary) stores the data ANDed with 0xF8 for the primary and 0xDE for the secondary; masked bits always read back as zero.
- R7: A trigger-mode bit of 0 selects edge mode: a rising input sets the pending bit and the acknowledge clears it. A bit of 1 selects level mode: the pending bit follows the input and survives the acknowledge.
- R8: Request input 2 has no effect; primary line 2 is driven only by the cascade.
- R9: int_o is re-evaluated after every acknowledge and stays high only while a unit still offers a request above its in-service level.
- R10: After reset int_o is 0, vector_o is 0 and both trigger-mode bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Interrupt request lines |
| ack_i | input | 1 | CPU acknowledge strobe, one cycle |
| vector_o | output | 8 | Vector of the last acknowledge |
| int_o | output | 1 | Interrupt request to the CPU |
| eoi_i | input | 1 | End-of-service strobe |
| eoi_line_i | input | 4 | Line released by eoi_i |
| trig_we_i | input | 1 | Trigger-mode byte write enable |
| trig_sel_i | input | 1 | Trigger-mode byte select, 0 primary, 1 secondary |
| trig_wdata_i | input | 8 | Trigger-mode write data |
| trig_rdata_o | output | 8 | Trigger-mode byte selected by trig_sel_i |

## Verification
A primary request is latched on the first clock edge after its input rises, so int_o follows one cycle later. A secondary request needs a second edge to cross the cascade line, so its int_o is due two cycles after the input rises. The vector, the in-service change and the new int_o level all appear one edge after the acknowledge, and an end-of-service strobe takes effect on the edge that samples it. The bench drives every input on the falling edge and samples on the next falling edge after exactly those edge counts. It also samples int_o one cycle early for a secondary request, which proves the two-stage delay.

// File: rtl/cascade_intack.sv
module cascade_intack #(
  parameter logic [7:0] PRI_VBASE = 8'h08,
  parameter logic [7:0] SEC_VBASE = 8'h70,
  parameter logic [7:0] PRI_TMASK = 8'hF8,
  parameter logic [7:0] SEC_TMASK = 8'hDE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] req_i,
  input  logic        ack_i,
  output logic [7:0]  vector_o,
  output logic        int_o,
  input  logic        eoi_i,
  input  logic [3:0]  eoi_line_i,
  input  logic        trig_we_i,
  input  logic        trig_sel_i,
  input  logic [7:0]  trig_wdata_i,
  output logic [7:0]  trig_rdata_o
);
  localparam logic [7:0] CASC_BIT = 8'h04;

  function automatic logic [3:0] first_set(input logic [7:0] v);
    first_set = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (v[i]) first_set = 4'(i);
  endfunction

  logic [15:0] req_q;
  logic [7:0]  p_irr, p_isr, p_trig;
  logic [7:0]  s_irr, s_isr, s_trig;

  logic [3:0] p_win, p_cur, s_win, s_cur;
  logic       p_ok, s_ok, p_take, s_take;
  logic [7:0] p_src, p_rise, s_rise;
  logic [7:0] p_ackb, s_ackb, p_eoib, s_eoib;
  logic [7:0] p_irr_nx, s_irr_nx;

  assign p_win = first_set(p_irr);
  assign p_cur = first_set(p_isr);
  assign s_win = first_set(s_irr);
  assign s_cur = first_set(s_isr);
  assign p_ok  = p_win < p_cur;
  assign s_ok  = s_win < s_cur;
  assign int_o = p_ok;

  assign p_take = ack_i && p_ok;
  assign s_take = p_take && (p_win == 4'd2) && s_ok;
  assign p_ackb = p_take ? (8'h01 << p_win[2:0]) : 8'h00;
  assign s_ackb = s_take ? (8'h01 << s_win[2:0]) : 8'h00;
  assign p_eoib = (eoi_i && !eoi_line_i[3]) ? (8'h01 << eoi_line_i[2:0]) : 8'h00;
  assign s_eoib = (eoi_i &&  eoi_line_i[3]) ? (8'h01 << eoi_line_i[2:0]) : 8'h00;

  assign p_src  = req_i[7:0] & ~CASC_BIT;
  assign p_rise = p_src & ~(req_q[7:0] & ~CASC_BIT);
  assign s_rise = req_i[15:8] & ~req_q[15:8];

  assign p_irr_nx = ((p_trig & p_src) | (~p_trig & (p_irr | p_rise)) | (s_ok ? CASC_BIT : 8'h00))
                    & ~(p_ackb & ~p_trig);
  assign s_irr_nx = ((s_trig & req_i[15:8]) | (~s_trig & (s_irr | s_rise)))
                    & ~(s_ackb & ~s_trig);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      p_irr    <= '0;
      p_isr    <= '0;
      s_irr    <= '0;
      s_isr    <= '0;
      p_trig   <= '0;
      s_trig   <= '0;
      vector_o <= '0;
    end else begin
      req_q <= req_i;
      p_irr <= p_irr_nx;
      s_irr <= s_irr_nx;
      p_isr <= (p_isr | p_ackb) & ~p_eoib;
      s_isr <= (s_isr | s_ackb) & ~s_eoib;
      if (trig_we_i && !trig_sel_i) p_trig <= trig_wdata_i & PRI_TMASK;
      if (trig_we_i &&  trig_sel_i) s_trig <= trig_wdata_i & SEC_TMASK;
      if (ack_i) begin
        if (!p_ok)
          vector_o <= PRI_VBASE + 8'd7;
        else if (p_win == 4'd2)
          vector_o <= s_ok ? SEC_VBASE + {5'd0, s_win[2:0]} : SEC_VBASE + 8'd7;
        else
          vector_o <= PRI_VBASE + {5'd0, p_win[2:0]};
      end
    end
  end

  assign trig_rdata_o = trig_sel_i ? s_trig : p_trig;

  assert_spurious_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o) |=> vector_o == PRI_VBASE + 8'd7);

  assert_spurious_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o && !eoi_i) |=> ($stable(p_isr) && $stable(s_isr)));

  assert_one_in_service_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o && !eoi_i) |=> $countones(p_isr) == $countones($past(p_isr)) + 1);

  assert_cascade_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o && p_win == 4'd2) |=> vector_o[7:3] == SEC_VBASE[7:3]);

  assert_trig_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we_i && trig_sel_i) |=> s_trig == ($past(trig_wdata_i) & SEC_TMASK));
endmodule

// File: tb/sim_cascade_intack.sv
module sim_cascade_intack;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_i = '0;
  logic        ack_i = 1'b0;
  logic [7:0]  vector_o;
  logic        int_o;
  logic        eoi_i = 1'b0;
  logic [3:0]  eoi_line_i = '0;
  logic        trig_we_i = 1'b0;
  logic        trig_sel_i = 1'b0;
  logic [7:0]  trig_wdata_i = '0;
  logic [7:0]  trig_rdata_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_intack u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i), .vector_o(vector_o),
    .int_o(int_o), .eoi_i(eoi_i), .eoi_line_i(eoi_line_i), .trig_we_i(trig_we_i),
    .trig_sel_i(trig_sel_i), .trig_wdata_i(trig_wdata_i), .trig_rdata_o(trig_rdata_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    req_i = '0; ack_i = 0; eoi_i = 0; trig_we_i = 0; trig_sel_i = 0;
    rst_n = 0; tick(2); rst_n = 1;
  endtask

  task automatic do_ack();
    ack_i = 1; tick(); ack_i = 0;
  endtask

  task automatic do_eoi(input int line);
    eoi_i = 1; eoi_line_i = 4'(line); tick(); eoi_i = 0;
  endtask

  task automatic set_trig(input bit sel, input logic [7:0] d);
    trig_we_i = 1; trig_sel_i = sel; trig_wdata_i = d; tick(); trig_we_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 int_o", int_o, 0);
    chk("R10 vector_o", vector_o, 0);
    trig_sel_i = 0; #1 chk("R10 primary trig", trig_rdata_o, 0);
    trig_sel_i = 1; #1 chk("R10 secondary trig", trig_rdata_o, 0);
  endtask

  task automatic t_trig_mask();
    do_reset();
    set_trig(0, 8'hFF); trig_sel_i = 0; #1 chk("R6 primary mask", trig_rdata_o, 8'hF8);
    set_trig(1, 8'hFF); trig_sel_i = 1; #1 chk("R6 secondary mask", trig_rdata_o, 8'hDE);
    set_trig(1, 8'h21); #1 chk("R6 secondary fixed bits", trig_rdata_o, 8'h00);
  endtask

  task automatic t_priority();
    do_reset();
    req_i[5] = 1; req_i[1] = 1; tick();
    chk("R1 int after one edge", int_o, 1);
    do_ack();
    chk("R1 lowest line wins", vector_o, 8'h09);
    chk("R9 lower line blocked after ack", int_o, 0);
    do_eoi(1);
    chk("R3 eoi releases line 5", int_o, 1);
    do_ack();
    chk("R1 second vector", vector_o, 8'h0D);
    do_eoi(5);
    chk("R9 nothing left", int_o, 0);
  endtask

  task automatic t_secondary();
    do_reset();
    req_i[12] = 1; tick();
    chk("R2 not yet through cascade", int_o, 0);
    tick();
    chk("R2 int after two edges", int_o, 1);
    do_ack();
    chk("R2 secondary vector", vector_o, 8'h74);
    chk("R9 int drops after cascade ack", int_o, 0);
  endtask

  task automatic t_input2();
    do_reset();
    req_i[2] = 1; tick(3);
    chk("R8 input 2 ignored", int_o, 0);
    do_ack();
    chk("R8 ack gives spurious", vector_o, 8'h0F);
  endtask

  task automatic t_spur_primary();
    do_reset();
    set_trig(0, 8'h08);
    req_i[3] = 1; tick();
    chk("R5 level line pending", int_o, 1);
    req_i[3] = 0; tick();
    chk("R5 level line gone", int_o, 0);
    do_ack();
    chk("R5 spurious primary vector", vector_o, 8'h0F);
    req_i[4] = 1; tick();
    chk("R5 no line entered service", int_o, 1);
    do_ack();
    chk("R5 following vector", vector_o, 8'h0C);
  endtask

  task automatic t_spur_secondary();
    do_reset();
    set_trig(1, 8'h02);
    req_i[9] = 1; tick(2);
    chk("R4 cascade raised", int_o, 1);
    req_i[9] = 0; tick();
    chk("R4 cascade still latched", int_o, 1);
    do_ack();
    chk("R4 spurious secondary vector", vector_o, 8'h77);
    chk("R4 int drops", int_o, 0);
    req_i[10] = 1; tick(2);
    chk("R3 cascade line in service blocks", int_o, 0);
    do_eoi(2);
    chk("R3 eoi on line 2 unblocks", int_o, 1);
    do_ack();
    chk("R2 line 10 vector", vector_o, 8'h72);
  endtask

  task automatic t_trigger_modes();
    do_reset();
    req_i[6] = 1; tick();
    do_ack();
    chk("R7 edge vector", vector_o, 8'h0E);
    do_eoi(6); tick();
    chk("R7 edge consumed while held", int_o, 0);
    req_i[6] = 0;
    set_trig(0, 8'h10);
    req_i[4] = 1; tick();
    do_ack();
    chk("R7 level vector", vector_o, 8'h0C);
    do_eoi(4);
    chk("R7 level stays pending", int_o, 1);
    req_i[4] = 0; tick();
    chk("R7 level follows input", int_o, 0);
    set_trig(1, 8'hFF);
    req_i[8] = 1; tick(2);
    do_ack();
    chk("R6 line 8 vector", vector_o, 8'h70);
    do_eoi(8); do_eoi(2); tick(2);
    chk("R6 line 8 forced edge", int_o, 0);
  endtask

  initial begin
    t_reset();
    t_trig_mask();
    t_priority();
    t_secondary();
    t_input2();
    t_spur_primary();
    t_spur_secondary();
    t_trigger_modes();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule